// File: doc/BRIEF.md
# Byte-Lane Data Parity Generator/Checker

This block sits beside a 64-bit processor data bus that carries one parity bit for each of its eight byte lanes. When the processor drives write data, the block produces an even-parity bit for every lane. It presents those bits together with an output enable. The enable is the data-bus drive enable passed straight through, so the parity lanes turn on and float in the same cycles as the data they protect.

On reads, the block samples the data and parity lanes on a data-ready strobe and checks each byte lane. A lane is checked only if it counts for the current cycle. On a single-transfer read, a lane counts when its active-low byte enable is asserted. On a burst read, all eight lanes count, whatever the byte enables are. If any lane that counts is in error, the active-low parity-check flag is pulled low for one clock. A registered vector, updated at the same moment, shows which lanes failed.

Top module: `lane_parity_unit`

## Requirements
- R1: While `data_oe` is 1, `par_out[i]` is the XOR of `wr_data[8i+7:8i]`, so that the lane's data byte and its parity bit together hold an even number of ones. Bit 7 covers data bits 63:56 and bit 0 covers data bits 7:0. The output is combinational and updates in the same cycle as the data.
- R2: `par_oe` equals `data_oe` in every cycle. While `par_oe` is 0, `par_out` is all zeros, which is the floated state.
- R3: On a clock edge where `rdy` is 1, lane i is in error when `rd_data[8i+7:8i]` and `rd_par[i]` together hold an odd number of ones. The masked result appears on `lane_err` after that edge.
- R4: When `burst` is 0, a lane i whose `be_n[i]` is 1 never shows an error, whatever its data and parity.
- R5: When `burst` is 1, all eight lanes are checked and `be_n` has no effect.
- R6: `pchk_n` is 0 in exactly the cycle after a sampled read with at least one checked lane in error. It is 1 after a clean sample and after any edge where `rdy` is 0.
- R7: A synchronous active-high `rst` sets `pchk_n` to 1 and `lane_err` to zero, and this takes priority over a sample in the same cycle.
- R8: After an edge where `rdy` is 0, `lane_err` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 64 | Write data being driven onto the bus |
| data_oe | input | 1 | Data-bus drive enable (write data phase) |
| par_out | output | 8 | Generated even-parity bits, zero when floated |
| par_oe | output | 1 | Parity-lane drive enable |
| rd_data | input | 64 | Data sampled from the bus on reads |
| rd_par | input | 8 | Parity sampled from the bus on reads |
| be_n | input | 8 | Byte enables, active low |
| burst | input | 1 | 1 = burst read, check all lanes |
| rdy | input | 1 | Data-ready strobe, samples read data and parity |
| pchk_n | output | 1 | Parity-check flag, active low, one clock |
| lane_err | output | 8 | Registered per-lane error vector |

## Verification
Generation of write parity and checking of sampled read parity run on separate paths, and both can be active in the same cycle. A bench might drive `data_oe` and `rdy` together and find that one path disturbs the other. To provoke this, every table vector drives write data and read data at the same time, with the strobe held high back to back. The combinational parity outputs are judged in the drive cycle. The error vector and flag are judged one edge later, each against values worked out from the lane rules, so that interference in either direction shows up. Directed cases then cover the masks, the one-cycle width of the flag, and reset colliding with a failing sample.

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       data_oe,
  output logic [DATA_W/LANE_W-1:0]   par_out,
  output logic                       par_oe,
  input  logic [DATA_W-1:0]          rd_data,
  input  logic [DATA_W/LANE_W-1:0]   rd_par,
  input  logic [DATA_W/LANE_W-1:0]   be_n,
  input  logic                       burst,
  input  logic                       rdy,
  output logic                       pchk_n,
  output logic [DATA_W/LANE_W-1:0]   lane_err
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] gen_par;
  logic [LANES-1:0] odd_lane;
  logic [LANES-1:0] chk_mask;
  logic [LANES-1:0] bad_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign gen_par[g]  = ^wr_data[g*LANE_W +: LANE_W];
    assign odd_lane[g] = ^{rd_data[g*LANE_W +: LANE_W], rd_par[g]};

    AST_GEN_EVEN: assert property (@(posedge clk) disable iff (rst)
      par_oe |-> !(^{wr_data[g*LANE_W +: LANE_W], par_out[g]})); // R1
  end

  assign par_oe   = data_oe;
  assign par_out  = data_oe ? gen_par : '0;
  assign chk_mask = burst ? {LANES{1'b1}} : ~be_n;
  assign bad_lane = odd_lane & chk_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      pchk_n   <= 1'b1;
      lane_err <= '0;
    end else if (rdy) begin
      pchk_n   <= ~|bad_lane;
      lane_err <= bad_lane;
    end else begin
      pchk_n   <= 1'b1;
      lane_err <= '0;
    end
  end

  AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !par_oe |-> (par_out == '0)); // R2

  AST_FLAG_VS_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (!pchk_n) == (lane_err != '0)); // R3

  AST_SINGLE_MASK: assert property (@(posedge clk) disable iff (rst)
    (rdy && !burst) |=> ((lane_err & $past(be_n)) == '0)); // R4

  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> pchk_n); // R6

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> (lane_err == '0)); // R8
endmodule

// File: tb/sim_lane_parity_unit.sv
`timescale 1ns/1ps
module sim_lane_parity_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] wr_data = '0;
  logic        data_oe = 1'b0;
  logic [7:0]  par_out;
  logic        par_oe;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_par = '0;
  logic [7:0]  be_n = 8'hFF;
  logic        burst = 1'b0;
  logic        rdy = 1'b0;
  logic        pchk_n;
  logic [7:0]  lane_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lane_parity_unit u0 (
    .clk(clk), .rst(rst), .wr_data(wr_data), .data_oe(data_oe),
    .par_out(par_out), .par_oe(par_oe), .rd_data(rd_data), .rd_par(rd_par),
    .be_n(be_n), .burst(burst), .rdy(rdy), .pchk_n(pchk_n), .lane_err(lane_err)
  );

  // fields: data[96:33] par[32:25] be_n[24:17] burst[16] exp_err[15:8] exp_gen[7:0]
  localparam logic [96:0] TAB [0:9] = '{
    {64'h0000000000000000, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},
    {64'h0000000000000000, 8'hA5, 8'h00, 1'b0, 8'hA5, 8'h00},
    {64'h0000000000000000, 8'hFF, 8'hF0, 1'b0, 8'h0F, 8'h00},
    {64'h0000000000000000, 8'hFF, 8'hFF, 1'b1, 8'hFF, 8'h00},
    {64'h0000000000000000, 8'hFF, 8'hFF, 1'b0, 8'h00, 8'h00},
    {64'hFFFFFFFFFFFFFFFF, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},
    {64'h0000000000000001, 8'h00, 8'h00, 1'b0, 8'h01, 8'h01},
    {64'h8000000000000000, 8'h80, 8'h00, 1'b0, 8'h00, 8'h80},
    {64'h8000000000000000, 8'h00, 8'h7F, 1'b0, 8'h80, 8'h80},
    {64'h0103070F1F3F7FFF, 8'h00, 8'hFF, 1'b1, 8'hAA, 8'hAA}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset pchk_n", {63'd0, pchk_n}, 64'd1);
    check("R7 reset lane_err", {56'd0, lane_err}, 64'd0);
    rst = 1'b0;

    // table walk: write generation and read checking in the same cycles
    for (int i = 0; i < 10; i++) begin
      wr_data = TAB[i][96:33];
      rd_data = TAB[i][96:33];
      rd_par  = TAB[i][32:25];
      be_n    = TAB[i][24:17];
      burst   = TAB[i][16];
      data_oe = 1'b1;
      rdy     = 1'b1;
      #1;
      check("R1 par_out", {56'd0, par_out}, {56'd0, TAB[i][7:0]});
      check("R2 par_oe", {63'd0, par_oe}, 64'd1);
      @(negedge clk);
      check("R3 R4 R5 lane_err", {56'd0, lane_err}, {56'd0, TAB[i][15:8]});
      check("R6 pchk_n", {63'd0, pchk_n}, {63'd0, (TAB[i][15:8] == 8'h00)});
    end

    // R2: parity lanes float with data enable off
    data_oe = 1'b0;
    wr_data = 64'h0000000000000001;
    #1;
    check("R2 par_oe off", {63'd0, par_oe}, 64'd0);
    check("R2 par_out floated", {56'd0, par_out}, 64'd0);

    // R6/R8: after a failing sample, strobe drops -> flag released in one cycle
    rd_data = '0; rd_par = 8'h01; be_n = 8'h00; burst = 1'b0; rdy = 1'b1;
    @(negedge clk);
    check("R6 flag on fail", {63'd0, pchk_n}, 64'd0);
    rdy = 1'b0;
    @(negedge clk);
    check("R6 flag one cycle", {63'd0, pchk_n}, 64'd1);
    check("R8 vector cleared", {56'd0, lane_err}, 64'd0);

    // R3: bad parity without strobe is never flagged
    rd_par = 8'hFF;
    @(negedge clk);
    check("R3 no strobe no flag", {63'd0, pchk_n}, 64'd1);
    check("R3 no strobe no vector", {56'd0, lane_err}, 64'd0);

    // R4: single-transfer, disabled lane error ignored, enabled lane caught
    rd_par = 8'h81; be_n = 8'h7E; burst = 1'b0; rdy = 1'b1;
    @(negedge clk);
    check("R4 disabled lanes masked", {56'd0, lane_err}, 64'h81);
    be_n = 8'h7F;
    @(negedge clk);
    check("R4 lane0 disabled", {56'd0, lane_err}, 64'h80);
    // R5: burst ignores the byte enables
    be_n = 8'hFF; burst = 1'b1;
    @(negedge clk);
    check("R5 burst all lanes", {56'd0, lane_err}, 64'h81);

    // R7: reset wins over a failing sample
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset over sample pchk_n", {63'd0, pchk_n}, 64'd1);
    check("R7 reset over sample lane_err", {56'd0, lane_err}, 64'd0);
    rst = 1'b0; rdy = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule